// File: doc/BRIEF.md
# Bus-Mapped Bidirectional GPIO Port

This block is an eight-pin general-purpose I/O port that sits on a simple register bus. Software writes an output value, a direction mask and a pair of pull-enable bits; the block turns these into per-pin drive enable, drive value and pull-enable signals for the pad ring. The pad's input level is brought through a two-stage synchronizer and can be read back over the same bus.

Each bit read from the value register comes from one of two places: a pin set as an output reports what the block is driving (the latch), and a pin set as an input reports the synchronized pad level. Pull resistors are requested in groups of four pins, and only on pins that are currently inputs. A build-time parameter chooses between a direction bit for every pin and a single direction bit that switches the whole port at once.

Top module: `gpio_port`

## Requirements
- R1: After reset the value latch is 0x00, all pins are inputs and no pull is requested: `pin_out`, `pin_oe` and `pin_pull` are all zero, and the direction and pull registers read 0x00.
- R2: A write takes effect on the rising clock edge where `wr_en` is 1; `addr` 0 selects the value latch, 1 the direction register, 2 the pull register. Before that edge the outputs keep their old values.
- R3: In per-pin mode, direction bit n equal to 1 sets `pin_oe[n]` to 1 (output) and 0 makes pin n an input; `pin_out` always presents the value latch.
- R4: A read at `addr` 0 returns, for each bit, the latch bit when that pin is an output and the synchronized pin level when it is an input.
- R5: Writing the value latch while a pin is an input leaves `pin_oe` for that pin at 0; the written value appears on `pin_out` and is driven once the pin is switched to output.
- R6: Pull register bit 0 requests pull on pins 0 to 3 and bit 1 on pins 4 to 7; `pin_pull[n]` is 1 only when pin n is an input and its group bit is 1.
- R7: Pull register bits 2 to 7 are not stored and read as 0.
- R8: A change on `pin_in` appears in a value read after the second rising clock edge following it, and not after the first.
- R9: In whole-port mode (`WHOLE_DIR`=1) only direction bit 0 is stored; it sets the direction of all eight pins, and direction bits 1 to 7 read as 0.
- R10: `addr` 3 holds no register: writes to it change no output and reads from it return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 value, 1 direction, 2 pull |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register, combinational |
| pin_in | input | 8 | Pad input levels, asynchronous |
| pin_out | output | 8 | Value to drive on each pad |
| pin_oe | output | 8 | Per-pad drive enable, 1 = output |
| pin_pull | output | 8 | Per-pad pull request |

## Verification
The hardest case to reach from the ports is a value read that mixes both sources in one byte, because it needs the direction mask, the latch and the pad levels set to disagreeing patterns at the same time, with the pad levels given two edges to cross the synchronizer. A table of vectors sets all three to split masks (nibbles, alternate bits) so each read holds latch bits and pad bits side by side, and pull requests against the same masks. Directed steps then probe the synchronizer edge by edge, write the latch behind input pins, and drive a second instance built in whole-port mode.

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int WIDTH     = 8,
  parameter int GROUP_W   = 4,
  parameter bit WHOLE_DIR = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe,
  output logic [WIDTH-1:0] pin_pull
);
  localparam int NGRP  = WIDTH / GROUP_W;
  localparam int DIR_W = WHOLE_DIR ? 1 : WIDTH;
  localparam logic [1:0] A_VAL  = 2'd0;
  localparam logic [1:0] A_DIR  = 2'd1;
  localparam logic [1:0] A_PULL = 2'd2;

  logic [WIDTH-1:0] lat_q, meta_q, sync_q;
  logic [DIR_W-1:0] dir_q;
  logic [NGRP-1:0]  pull_q;
  logic [WIDTH-1:0] dir_bits, dir_rd, grp_pull;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= '0;
      dir_q  <= '0;
      pull_q <= '0;
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
      if (wr_en) begin
        case (addr)
          A_VAL:   lat_q  <= wdata;
          A_DIR:   dir_q  <= wdata[DIR_W-1:0];
          A_PULL:  pull_q <= wdata[NGRP-1:0];
          default: ;
        endcase
      end
    end
  end

  generate
    if (WHOLE_DIR) begin : g_whole
      assign dir_bits = {WIDTH{dir_q[0]}};
      assign dir_rd   = {{(WIDTH-1){1'b0}}, dir_q[0]};
    end else begin : g_perbit
      assign dir_bits = dir_q;
      assign dir_rd   = dir_q;
    end
  endgenerate

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp_pull[g*GROUP_W +: GROUP_W] = {GROUP_W{pull_q[g]}};
  end

  assign pin_out  = lat_q;
  assign pin_oe   = dir_bits;
  assign pin_pull = grp_pull & ~dir_bits;

  always_comb begin
    case (addr)
      A_VAL:   rdata = (lat_q & dir_bits) | (sync_q & ~dir_bits);
      A_DIR:   rdata = dir_rd;
      A_PULL:  rdata = {{(WIDTH-NGRP){1'b0}}, pull_q};
      default: rdata = '0;
    endcase
  end

  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= '0;
    else if (age_q != 2'd2)  age_q <= age_q + 2'd1;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd0) |-> (pin_oe == '0 && pin_pull == '0 && pin_out == '0));

  assert_latch_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_VAL) |=> (pin_out == $past(wdata)));

  assert_sync_depth_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2) |-> (sync_q == $past(pin_in, 2)));

  assert_dead_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd3) |=> ($stable(pin_out) && $stable(pin_oe) && $stable(pin_pull)));

  generate
    if (WHOLE_DIR) begin : g_chk_whole
      assert_whole_dir_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_DIR) |=> (pin_oe == {WIDTH{$past(wdata[0])}}));
    end else begin : g_chk_perbit
      assert_dir_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_DIR) |=> (pin_oe == $past(wdata)));
    end
  endgenerate
endmodule

// File: tb/test_gpio_port.sv
module test_gpio_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_a = 1'b0, wr_b = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] pin_in = 8'h00;
  logic [7:0] rd_a, out_a, oe_a, pull_a;
  logic [7:0] rd_b, out_b, oe_b, pull_b;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_port i_gpio_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_a), .addr(addr), .wdata(wdata),
    .rdata(rd_a), .pin_in(pin_in), .pin_out(out_a), .pin_oe(oe_a), .pin_pull(pull_a));

  gpio_port #(.WHOLE_DIR(1'b1)) i_gpio_port_whole (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_b), .addr(addr), .wdata(wdata),
    .rdata(rd_b), .pin_in(pin_in), .pin_out(out_b), .pin_oe(oe_b), .pin_pull(pull_b));

  // dir, latch, pins, pull, expected read, expected oe, expected pull
  localparam logic [55:0] VEC [6] = '{
    {8'h00, 8'hAA, 8'h3C, 8'h00, 8'h3C, 8'h00, 8'h00},
    {8'hFF, 8'h5A, 8'h00, 8'h03, 8'h5A, 8'hFF, 8'h00},
    {8'hF0, 8'h96, 8'h0F, 8'h01, 8'h9F, 8'hF0, 8'h0F},
    {8'h0F, 8'h12, 8'hC3, 8'h02, 8'hC2, 8'h0F, 8'hF0},
    {8'h55, 8'hFF, 8'h00, 8'h03, 8'h55, 8'h55, 8'hAA},
    {8'hA5, 8'h00, 8'hFF, 8'h03, 8'h5A, 8'hA5, 8'h5A}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input bit whole, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_a = !whole; wr_b = whole;
    @(negedge clk);
    wr_a = 1'b0; wr_b = 1'b0;
  endtask

  task automatic look(input logic [1:0] a);
    addr = a;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    look(2'd1);
    check("R1 reset dir read", rd_a, 8'h00);
    check("R1 reset oe", oe_a, 8'h00);
    check("R1 reset out", out_a, 8'h00);
    check("R1 reset pull", pull_a, 8'h00);
    look(2'd2);
    check("R1 reset pull read", rd_a, 8'h00);

    foreach (VEC[i]) begin
      wr(0, 2'd1, VEC[i][55:48]);
      wr(0, 2'd0, VEC[i][47:40]);
      wr(0, 2'd2, VEC[i][31:24]);
      pin_in = VEC[i][39:32];
      repeat (3) @(negedge clk);
      look(2'd0);
      check("R4 mixed read", rd_a, VEC[i][23:16]);
      check("R3 oe", oe_a, VEC[i][15:8]);
      check("R3 out", out_a, VEC[i][47:40]);
      check("R6 pull", pull_a, VEC[i][7:0]);
    end

    // R2: value appears only after the write edge
    wr(0, 2'd1, 8'hFF);
    @(negedge clk);
    addr = 2'd0; wdata = 8'h3E; wr_a = 1'b1;
    #1 check("R2 before edge", out_a, 8'h00);
    @(negedge clk);
    wr_a = 1'b0;
    #1 check("R2 after edge", out_a, 8'h3E);

    // R7
    wr(0, 2'd2, 8'hFF);
    look(2'd2);
    check("R7 pull unused bits", rd_a, 8'h03);

    // R10
    wr(0, 2'd3, 8'hA5);
    look(2'd3);
    check("R10 dead addr read", rd_a, 8'h00);
    check("R10 out unchanged", out_a, 8'h3E);
    check("R10 oe unchanged", oe_a, 8'hFF);

    // R5: latch written behind input pins
    wr(0, 2'd1, 8'h00);
    wr(0, 2'd0, 8'hC3);
    check("R5 still input", oe_a, 8'h00);
    check("R5 latch on out", out_a, 8'hC3);
    check("R6 pull all inputs", pull_a, 8'hFF);
    wr(0, 2'd1, 8'hFF);
    look(2'd0);
    check("R5 driven later", rd_a, 8'hC3);
    check("R6 pull gated", pull_a, 8'h00);

    // R8: synchronizer depth
    wr(0, 2'd1, 8'h00);
    pin_in = 8'h00;
    repeat (3) @(negedge clk);
    pin_in = 8'h81;
    look(2'd0);
    @(negedge clk);
    #1 check("R8 after one edge", rd_a, 8'h00);
    @(negedge clk);
    #1 check("R8 after two edges", rd_a, 8'h81);

    // R9: whole-port instance
    wr(1, 2'd1, 8'hFE);
    look(2'd1);
    check("R9 bit0 clear", oe_b, 8'h00);
    check("R9 dir read clear", rd_b, 8'h00);
    wr(1, 2'd1, 8'h01);
    look(2'd1);
    check("R9 bit0 set", oe_b, 8'hFF);
    check("R9 dir read", rd_b, 8'h01);
    wr(1, 2'd1, 8'hFF);
    look(2'd1);
    check("R9 upper bits read 0", rd_b, 8'h01);
    wr(1, 2'd2, 8'h03);
    check("R9 pull gated all out", pull_b, 8'h00);
    wr(1, 2'd0, 8'h6D);
    look(2'd0);
    check("R9 whole read latch", rd_b, 8'h6D);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule